// File: doc/BRIEF.md
# PCI Burst Initiator

This block is the initiator side of a 32-bit PCI bus interface. A simple back-end requester announces a transfer with a one-cycle strobe. With the strobe it gives the start address on a shared address/data input, a direction bit, a memory-or-I/O select, byte enables and a 6-bit burst length. The block asks for the bus through the request/grant handshake and drives the address phase with the matching bus command. It then runs one data phase or a burst of data phases, one per clock whenever the target is ready.

Write data is loaded into an internal buffer before the bus is requested. The back-end is told when its last word has been taken. Read data is returned one word at a time with a ready pulse. A target may end a transaction early with a retry or a disconnect. The block then requests the bus again on its own and carries on from the first address that was not transferred.

Completion is reported with a done pulse. An abnormal end pairs done with back-off. Back-off on its own tells the back-end that its new strobe was refused because the initiator is busy.

PCI control pins are modelled as logical levels where 1 means asserted. Any pad inversion and tri-state buffering sit outside the block.

Top module: `pci_burst_initiator`

## Requirements
- R1: The burst length code gives the number of data phases. Code 1 means one phase, code 0 means 64 phases, and any other code N means N phases.
- R2: When the early-request input is sampled high while the block is idle, the bus request output is high in the next cycle.
- R3: In the address phase, C/BE carries 4'b0110 for a memory read, 4'b0111 for a memory write, 4'b0010 for an I/O read and 4'b0011 for an I/O write. In every data phase, C/BE carries the strobed byte enables.
- R4: On a write, the back-end ready output pulses one cycle after the final write word is sampled. The write words go onto AD in load order. Done pulses only after the last PCI data phase has completed.
- R5: A data phase completes on a clock where IRDY and TRDY are both high. Phases complete back to back with no wait states when TRDY stays high. FRAME is low during the final data phase and high during every earlier one.
- R6: STOP during a data phase ends the transaction. The block then raises its request again and issues a new address phase at the start address plus 4 for each phase already completed. It continues until all phases are done, with no action from the back-end.
- R7: The parity output is driven high-enable in the cycle after every cycle in which the block drives AD. It gives even parity over the previous cycle's AD[31:0] and C/BE[3:0].
- R8: If DEVSEL is not seen in the first 5 data cycles of a transaction, the transaction is dropped. Done and back-off then pulse together in the following cycle.
- R9: STOP together with DEVSEL low, after DEVSEL was seen earlier in the transaction, is a target abort. Done and back-off then pulse together and no further phases run.
- R10: A strobe that arrives while a transaction is in progress is refused. Back-off pulses in the next cycle without done.
- R11: After reset, request, FRAME, IRDY, the AD and parity enables, ready, done and back-off are all low.
- R12: On a read, each completed data phase returns the AD input word sampled at that clock on the read-data output, with a ready pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| be_hint | input | 1 | Early request, one cycle before the strobe |
| be_strobe | input | 1 | Starts a transfer; address is on be_adin |
| be_adin | input | 32 | Address at strobe, write word when be_wvalid |
| be_wvalid | input | 1 | Write word valid on be_adin |
| be_write | input | 1 | 1 write, 0 read |
| be_mem | input | 1 | 1 memory space, 0 I/O space |
| be_byten | input | 4 | Byte enables for all data phases |
| be_len | input | 6 | Burst length code |
| be_rdy | output | 1 | Last write word taken / read word valid |
| be_rdata | output | 32 | Read word |
| be_done | output | 1 | Transaction finished |
| be_boff | output | 1 | Back-off (with done: abort; alone: refused) |
| pci_req | output | 1 | Bus request |
| pci_gnt | input | 1 | Bus grant |
| pci_frame | output | 1 | FRAME |
| pci_irdy | output | 1 | IRDY |
| pci_ad_out | output | 32 | AD drive value |
| pci_ad_oe | output | 1 | AD drive enable |
| pci_cbe | output | 4 | C/BE drive value |
| pci_par | output | 1 | PAR drive value |
| pci_par_oe | output | 1 | PAR drive enable |
| pci_ad_in | input | 32 | AD as seen on the bus |
| pci_trdy | input | 1 | TRDY |
| pci_stop | input | 1 | STOP |
| pci_devsel | input | 1 | DEVSEL |

## Verification
Each result has a fixed latency from the clock edge that causes it. The address phase is on AD and C/BE one cycle after grant is sampled. A write word is on AD in the same cycle that its completing edge samples TRDY. Read data, load-ready, done and refusal back-off all appear one cycle after their causing edge. Parity trails its AD cycle by one cycle, and a master abort follows the fifth data cycle. The bench drives every input on the falling edge and samples every output on the next falling edge. It decides the target's TRDY/STOP for the coming rising edge before it counts a phase as complete, so each comparison lands exactly on the cycle the requirement names.

// File: rtl/pci_init_pkg.sv
package pci_init_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_ARB,
    S_ADDR,
    S_DATA
  } ini_state_t;

  // bus command: bit2 selects memory space, bit0 selects write
  function automatic logic [3:0] pick_cmd(input logic mem, input logic wr);
    return {1'b0, mem, 1'b1, wr};
  endfunction

endpackage

// File: rtl/pci_wr_buffer.sv
module pci_wr_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe,
  input  logic             drive,
  output logic             par,
  output logic             par_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      par    <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par    <= ^{ad, cbe};
      par_oe <= drive;
    end
  end

endmodule

// File: rtl/pci_devsel_timer.sv
module pci_devsel_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic active,
  input  logic devsel,
  output logic seen,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (active) begin
      if (devsel) seen <= 1'b1;
      if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
    end
  end

  assign expired = active && !seen && !devsel && (cnt == CW'(LIMIT - 1));

  // R8: once a target has claimed the transaction it stays claimed
  a_r8_seen_holds: assert property (@(posedge clk) disable iff (rst)
    (seen && !clear) |=> seen);

endmodule

// File: rtl/pci_burst_initiator.sv
module pci_burst_initiator
  import pci_init_pkg::*;
#(
  parameter int AD_W         = 32,
  parameter int BE_W         = 4,
  parameter int LEN_W        = 6,
  parameter int DEVSEL_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             be_hint,
  input  logic             be_strobe,
  input  logic [AD_W-1:0]  be_adin,
  input  logic             be_wvalid,
  input  logic             be_write,
  input  logic             be_mem,
  input  logic [BE_W-1:0]  be_byten,
  input  logic [LEN_W-1:0] be_len,
  output logic             be_rdy,
  output logic [AD_W-1:0]  be_rdata,
  output logic             be_done,
  output logic             be_boff,
  output logic             pci_req,
  input  logic             pci_gnt,
  output logic             pci_frame,
  output logic             pci_irdy,
  output logic [AD_W-1:0]  pci_ad_out,
  output logic             pci_ad_oe,
  output logic [BE_W-1:0]  pci_cbe,
  output logic             pci_par,
  output logic             pci_par_oe,
  input  logic [AD_W-1:0]  pci_ad_in,
  input  logic             pci_trdy,
  input  logic             pci_stop,
  input  logic             pci_devsel
);

  localparam int MAX_LEN = 2 ** LEN_W;
  localparam int CNT_W   = LEN_W + 1;
  localparam int PTR_W   = $clog2(MAX_LEN);

  ini_state_t       st;
  logic [AD_W-1:0]  addr_q;
  logic [3:0]       cmd_q;
  logic [BE_W-1:0]  byten_q;
  logic             wr_q;
  logic             show_addr;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] load_q;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] rd_ptr_n;
  logic [AD_W-1:0]  buf_q;
  logic [CNT_W-1:0] len_full;
  logic             dev_seen;
  logic             tmo_exp;
  logic             t_abort;
  logic             any_abort;
  logic             xfer;

  assign len_full  = (be_len == '0) ? CNT_W'(MAX_LEN) : {1'b0, be_len};
  assign xfer      = (st == S_DATA) && pci_trdy;
  assign t_abort   = (st == S_DATA) && pci_stop && !pci_devsel && dev_seen;
  assign any_abort = tmo_exp || t_abort;
  assign rd_ptr_n  = (st == S_IDLE) ? '0 :
                     (xfer && !any_abort) ? rd_ptr + PTR_W'(1) : rd_ptr;
  assign pci_ad_out = show_addr ? addr_q : buf_q;

  pci_wr_buffer #(.DW(AD_W), .DEPTH(MAX_LEN)) u_wbuf (
    .clk   (clk),
    .we    ((st == S_LOAD) && be_wvalid),
    .waddr (load_q[PTR_W-1:0]),
    .wdata (be_adin),
    .raddr (rd_ptr_n),
    .rdata (buf_q)
  );

  pci_par_gen #(.AD_W(AD_W), .CBE_W(BE_W)) u_par (
    .clk    (clk),
    .rst    (rst),
    .ad     (pci_ad_out),
    .cbe    (pci_cbe),
    .drive  (pci_ad_oe),
    .par    (pci_par),
    .par_oe (pci_par_oe)
  );

  pci_devsel_timer #(.LIMIT(DEVSEL_LIMIT)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .clear   (st == S_ADDR),
    .active  (st == S_DATA),
    .devsel  (pci_devsel),
    .seen    (dev_seen),
    .expired (tmo_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      cmd_q     <= '0;
      byten_q   <= '0;
      wr_q      <= 1'b0;
      show_addr <= 1'b0;
      left_q    <= '0;
      load_q    <= '0;
      rd_ptr    <= '0;
      be_rdy    <= 1'b0;
      be_rdata  <= '0;
      be_done   <= 1'b0;
      be_boff   <= 1'b0;
      pci_req   <= 1'b0;
      pci_frame <= 1'b0;
      pci_irdy  <= 1'b0;
      pci_ad_oe <= 1'b0;
      pci_cbe   <= '0;
    end else begin
      be_rdy  <= 1'b0;
      be_done <= 1'b0;
      be_boff <= 1'b0;
      rd_ptr  <= rd_ptr_n;
      if (be_strobe && st != S_IDLE) be_boff <= 1'b1;
      case (st)
        S_IDLE: begin
          pci_req <= be_hint | be_strobe;
          load_q  <= '0;
          if (be_strobe) begin
            addr_q  <= be_adin;
            cmd_q   <= pick_cmd(be_mem, be_write);
            byten_q <= be_byten;
            wr_q    <= be_write;
            left_q  <= len_full;
            st      <= be_write ? S_LOAD : S_ARB;
          end
        end
        S_LOAD: begin
          if (be_wvalid) begin
            load_q <= load_q + CNT_W'(1);
            if (load_q == left_q - CNT_W'(1)) begin
              be_rdy <= 1'b1;
              st     <= S_ARB;
            end
          end
        end
        S_ARB: begin
          pci_req <= 1'b1;
          if (pci_gnt) begin
            pci_req   <= 1'b0;
            pci_frame <= 1'b1;
            pci_ad_oe <= 1'b1;
            show_addr <= 1'b1;
            pci_cbe   <= cmd_q;
            st        <= S_ADDR;
          end
        end
        S_ADDR: begin
          show_addr <= 1'b0;
          pci_irdy  <= 1'b1;
          pci_frame <= (left_q != CNT_W'(1));
          pci_cbe   <= byten_q;
          pci_ad_oe <= wr_q;
          st        <= S_DATA;
        end
        S_DATA: begin
          if (any_abort) begin
            pci_frame <= 1'b0;
            pci_irdy  <= 1'b0;
            pci_ad_oe <= 1'b0;
            be_done   <= 1'b1;
            be_boff   <= 1'b1;
            st        <= S_IDLE;
          end else if (xfer) begin
            addr_q <= addr_q + AD_W'(4);
            left_q <= left_q - CNT_W'(1);
            if (!wr_q) begin
              be_rdata <= pci_ad_in;
              be_rdy   <= 1'b1;
            end
            if (left_q == CNT_W'(1)) begin
              pci_frame <= 1'b0;
              pci_irdy  <= 1'b0;
              pci_ad_oe <= 1'b0;
              be_done   <= 1'b1;
              st        <= S_IDLE;
            end else if (pci_stop) begin
              pci_frame <= 1'b0;
              pci_irdy  <= 1'b0;
              pci_ad_oe <= 1'b0;
              pci_req   <= 1'b1;
              st        <= S_ARB;
            end else begin
              pci_frame <= (left_q != CNT_W'(2));
            end
          end else if (pci_stop) begin
            pci_frame <= 1'b0;
            pci_irdy  <= 1'b0;
            pci_ad_oe <= 1'b0;
            pci_req   <= 1'b1;
            st        <= S_ARB;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: early request reaches the bus one cycle later
  a_r2_hint_req: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && be_hint) |=> pci_req);

  // R5: outside the address phase FRAME is only ever held with IRDY
  a_r5_frame_with_irdy: assert property (@(posedge clk) disable iff (rst)
    (pci_frame && !show_addr) |-> pci_irdy);

  // R4: done is only reported once the bus has been released
  a_r4_done_bus_free: assert property (@(posedge clk) disable iff (rst)
    be_done |-> (!pci_frame && !pci_irdy));

  // R7: every driven AD cycle is followed by a driven parity cycle
  a_r7_par_follows_ad: assert property (@(posedge clk) disable iff (rst)
    pci_ad_oe |=> pci_par_oe);

  // R10: a strobe while busy is refused with back-off
  a_r10_busy_refused: assert property (@(posedge clk) disable iff (rst)
    (be_strobe && st != S_IDLE) |=> be_boff);

  // R1: a data phase never runs with nothing left to transfer
  a_r1_left_nonzero: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA) |-> (left_q != '0));

endmodule

// File: tb/pci_burst_initiator_bench.sv
module pci_burst_initiator_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        be_hint, be_strobe, be_wvalid, be_write, be_mem;
  logic [31:0] be_adin;
  logic [3:0]  be_byten;
  logic [5:0]  be_len;
  logic        be_rdy, be_done, be_boff;
  logic [31:0] be_rdata;
  logic        pci_req, pci_gnt, pci_frame, pci_irdy, pci_ad_oe;
  logic [31:0] pci_ad_out, pci_ad_in;
  logic [3:0]  pci_cbe;
  logic        pci_par, pci_par_oe, pci_trdy, pci_stop, pci_devsel;

  always #5 clk = ~clk;

  pci_burst_initiator u_pci_burst_initiator (
    .clk(clk), .rst(rst), .be_hint(be_hint), .be_strobe(be_strobe),
    .be_adin(be_adin), .be_wvalid(be_wvalid), .be_write(be_write),
    .be_mem(be_mem), .be_byten(be_byten), .be_len(be_len),
    .be_rdy(be_rdy), .be_rdata(be_rdata), .be_done(be_done), .be_boff(be_boff),
    .pci_req(pci_req), .pci_gnt(pci_gnt), .pci_frame(pci_frame),
    .pci_irdy(pci_irdy), .pci_ad_out(pci_ad_out), .pci_ad_oe(pci_ad_oe),
    .pci_cbe(pci_cbe), .pci_par(pci_par), .pci_par_oe(pci_par_oe),
    .pci_ad_in(pci_ad_in), .pci_trdy(pci_trdy), .pci_stop(pci_stop),
    .pci_devsel(pci_devsel)
  );

  int vec_cnt = 0;
  int err_cnt = 0;

  // scoreboard queues
  logic [35:0] exp_addr_q[$];
  logic [31:0] exp_wdat_q[$];
  logic [31:0] exp_rdat_q[$];

  // target model configuration and state
  int          t_stop_at   = -1;
  bit          t_stop_data = 1'b0;
  bit          t_devsel_en = 1'b1;
  bit          t_tabort    = 1'b0;
  bit          stop_used   = 1'b0;
  int          t_cnt = 0;
  int          dcyc  = 0;
  int          tot_xfer  = 0;
  int          exp_total = 0;
  logic [31:0] t_addr = '0;
  logic [3:0]  exp_byten = '0;
  bit          cur_wr = 1'b0;
  logic [31:0] prev_ad = '0;
  logic [3:0]  prev_cbe = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_pattern(input logic [31:0] a);
    return a ^ 32'hA5C3_0000;
  endfunction

  // target, arbiter and monitor: decide drives for the coming rising edge
  always @(negedge clk) begin
    logic [35:0] ea;
    logic [31:0] ew;
    if (rst) begin
      pci_gnt = 1'b0; pci_trdy = 1'b0; pci_stop = 1'b0; pci_devsel = 1'b0;
      pci_ad_in = '0;
    end else begin
      pci_gnt = pci_req;
      if (pci_par_oe) chk("R7 parity", {31'b0, pci_par}, {31'b0, ^{prev_ad, prev_cbe}});
      prev_ad  = pci_ad_out;
      prev_cbe = pci_cbe;
      if (pci_frame && !pci_irdy) begin
        if (exp_addr_q.size() == 0) chk("R6 unexpected address phase", pci_ad_out, 32'hxxxx_xxxx);
        else begin
          ea = exp_addr_q.pop_front();
          chk("R6 address", pci_ad_out, ea[31:0]);
          chk("R3 command", {28'b0, pci_cbe}, {28'b0, ea[35:32]});
        end
        t_cnt = 0; dcyc = 0; t_addr = pci_ad_out;
      end
      pci_trdy = 1'b0; pci_stop = 1'b0; pci_devsel = 1'b0;
      if (pci_irdy) begin
        pci_devsel = t_devsel_en;
        pci_trdy   = t_devsel_en;
        if (t_tabort) begin
          pci_trdy = 1'b0;
          if (dcyc == 0) pci_devsel = 1'b1;
          else begin pci_devsel = 1'b0; pci_stop = 1'b1; end
        end else if (t_stop_at >= 0 && !stop_used && t_cnt == t_stop_at) begin
          pci_stop  = 1'b1;
          pci_trdy  = t_stop_data;
          stop_used = 1'b1;
        end
        dcyc++;
      end
      pci_ad_in = rd_pattern(t_addr);
      if (pci_irdy && pci_trdy) begin
        chk("R5 frame low only on last phase", {31'b0, pci_frame},
            {31'b0, (tot_xfer + 1 != exp_total)});
        chk("R3 byte enables", {28'b0, pci_cbe}, {28'b0, exp_byten});
        if (cur_wr) begin
          if (exp_wdat_q.size() == 0) chk("R4 unexpected write word", pci_ad_out, 32'hxxxx_xxxx);
          else begin
            ew = exp_wdat_q.pop_front();
            chk("R4 write word", pci_ad_out, ew);
          end
        end
        tot_xfer++; t_cnt++; t_addr = t_addr + 32'd4;
      end
      if (be_rdy && !cur_wr) begin
        if (exp_rdat_q.size() == 0) chk("R12 unexpected read word", be_rdata, 32'hxxxx_xxxx);
        else begin
          ew = exp_rdat_q.pop_front();
          chk("R12 read word", be_rdata, ew);
        end
      end
    end
  end

  task automatic wait_done(input logic exp_boff, input string tag);
    while (be_done !== 1'b1) @(negedge clk);
    chk(tag, {31'b0, be_boff}, {31'b0, exp_boff});
    @(negedge clk);
  endtask

  task automatic run_xfer(input bit wr, input bit mem, input logic [31:0] addr,
                          input logic [5:0] len, input logic [3:0] be,
                          input int stop_at, input bit stop_data, input bit hint);
    int n;
    logic [3:0] cmd;
    logic [31:0] words[$];
    n = (len == 6'd0) ? 64 : int'(len);
    cmd = mem ? (wr ? 4'b0111 : 4'b0110) : (wr ? 4'b0011 : 4'b0010);
    t_stop_at = stop_at; t_stop_data = stop_data; stop_used = 1'b0;
    t_devsel_en = 1'b1; t_tabort = 1'b0;
    cur_wr = wr; exp_byten = be; exp_total = n; tot_xfer = 0;
    exp_addr_q.push_back({cmd, addr});
    if (stop_at >= 0 && (stop_at + int'(stop_data)) < n)
      exp_addr_q.push_back({cmd, addr + 32'(4 * (stop_at + int'(stop_data)))});
    for (int i = 0; i < n; i++) begin
      if (wr) begin
        words.push_back(32'hC0DE_0000 ^ (addr << 4) ^ 32'(i * 32'h0101));
        exp_wdat_q.push_back(words[i]);
      end else begin
        exp_rdat_q.push_back(rd_pattern(addr + 32'(4 * i)));
      end
    end
    if (hint) begin
      chk("R2 request low before hint", {31'b0, pci_req}, 32'd0);
      be_hint = 1'b1;
      @(negedge clk);
      be_hint = 1'b0;
      chk("R2 request after hint", {31'b0, pci_req}, 32'd1);
    end
    be_strobe = 1'b1; be_adin = addr; be_write = wr; be_mem = mem;
    be_byten = be; be_len = len;
    @(negedge clk);
    be_strobe = 1'b0;
    if (wr) begin
      for (int i = 0; i < n; i++) begin
        be_wvalid = 1'b1; be_adin = words[i];
        @(negedge clk);
      end
      be_wvalid = 1'b0;
      chk("R4 ready after last word", {31'b0, be_rdy}, 32'd1);
      chk("R4 no done before bus phases", {31'b0, be_done}, 32'd0);
    end
    wait_done(1'b0, "R4 normal done without back-off");
    chk("R1 data phase count", 32'(tot_xfer), 32'(n));
    chk("R6 address queue drained", 32'(exp_addr_q.size()), 32'd0);
    chk("R12 data queues drained", 32'(exp_rdat_q.size() + exp_wdat_q.size()), 32'd0);
  endtask

  initial begin
    rst = 1'b1;
    be_hint = 1'b0; be_strobe = 1'b0; be_wvalid = 1'b0; be_write = 1'b0;
    be_mem = 1'b0; be_adin = '0; be_byten = '0; be_len = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: quiet outputs after reset
    chk("R11 reset req", {31'b0, pci_req}, 32'd0);
    chk("R11 reset frame/irdy", {30'b0, pci_frame, pci_irdy}, 32'd0);
    chk("R11 reset enables", {30'b0, pci_ad_oe, pci_par_oe}, 32'd0);
    chk("R11 reset back-end flags", {29'b0, be_rdy, be_done, be_boff}, 32'd0);

    run_xfer(1'b1, 1'b1, 32'h0000_1000, 6'd4, 4'hF, -1, 1'b0, 1'b1);  // R1 R2 R3 R4 R5
    run_xfer(1'b0, 1'b1, 32'h0000_2040, 6'd1, 4'h3, -1, 1'b0, 1'b0);  // R1 single
    run_xfer(1'b1, 1'b0, 32'h0000_0300, 6'd3, 4'hC, 1, 1'b0, 1'b0);   // R6 disconnect
    run_xfer(1'b0, 1'b0, 32'h0000_0480, 6'd5, 4'h1, 0, 1'b0, 1'b1);   // R6 retry
    run_xfer(1'b0, 1'b1, 32'h0001_0000, 6'd4, 4'hF, 1, 1'b1, 1'b0);   // R6 stop with data
    run_xfer(1'b1, 1'b1, 32'h0002_0000, 6'd0, 4'hA, -1, 1'b0, 1'b0);  // R1 code 0 = 64

    // R8 master abort, with R10 busy strobe during the data cycles
    t_devsel_en = 1'b0; t_tabort = 1'b0; t_stop_at = -1;
    cur_wr = 1'b0; exp_byten = 4'hF; exp_total = 2; tot_xfer = 0;
    exp_addr_q.push_back({4'b0110, 32'h0003_0000});
    be_strobe = 1'b1; be_adin = 32'h0003_0000; be_write = 1'b0; be_mem = 1'b1;
    be_byten = 4'hF; be_len = 6'd2;
    @(negedge clk);
    be_strobe = 1'b0;
    while (pci_irdy !== 1'b1) @(negedge clk);
    be_strobe = 1'b1; be_adin = 32'h0000_0DEA;
    @(negedge clk);
    be_strobe = 1'b0;
    chk("R10 back-off on busy strobe", {31'b0, be_boff}, 32'd1);
    chk("R10 no done with refusal", {31'b0, be_done}, 32'd0);
    wait_done(1'b1, "R8 master abort back-off with done");
    chk("R8 data cycles before abort", 32'(dcyc), 32'd5);
    chk("R8 no phase completed", 32'(tot_xfer), 32'd0);

    // R9 target abort
    t_devsel_en = 1'b1; t_tabort = 1'b1;
    cur_wr = 1'b0; exp_total = 3; tot_xfer = 0;
    exp_addr_q.push_back({4'b0010, 32'h0000_0600});
    be_strobe = 1'b1; be_adin = 32'h0000_0600; be_write = 1'b0; be_mem = 1'b0;
    be_byten = 4'h5; be_len = 6'd3;
    @(negedge clk);
    be_strobe = 1'b0;
    wait_done(1'b1, "R9 target abort back-off with done");
    chk("R9 no phase completed", 32'(tot_xfer), 32'd0);
    chk("R9 no restart", {31'b0, pci_req}, 32'd0);
    t_tabort = 1'b0;

    run_xfer(1'b0, 1'b1, 32'h0000_7000, 6'd2, 4'hF, -1, 1'b0, 1'b0);  // recovery

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vec_cnt++;
    err_cnt++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule